// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block runs one of four maintenance commands over a small nonvolatile byte array that is held inside the design as a register array. Software prepares the operation through a byte-wide register port. It loads a command code, a 16-bit start pointer, a 16-bit compare (end) value and a data byte. It then pulses an execute strobe. The sequencer raises busy and handles one array byte per clock. After each byte it advances the pointer by one, and it stops once the pointer equals the compare value.

The four commands are byte write, block erase, block blank check and internal verify. An erased byte reads FFH. A write may only turn 1 bits into 0 bits. A write that would turn a 0 bit into a 1 bit is refused and reported. Errors collect in a 3-bit sticky status register, and software clears its bits by writing 1s to them. Writing an unknown command code drops the block out of self-programming mode. This happens silently, and execute strobes are then ignored until a legal code is written.

Top module: `flash_cmd_seq`

## Requirements
- R1: Register selects (reg_sel) are 0 command, 1 pointer low byte, 2 pointer high byte, 3 compare low byte, 4 compare high byte, 5 data byte, 6 status clear. Writing a command byte whose bits 7:2 are zero enters self-programming mode (sp_mode_o=1). Bits 1:0 then select the command: 00 blank check, 01 verify, 10 byte write, 11 block erase.
- R2: Writing a command byte with any of bits 7:2 set clears sp_mode_o in the next cycle. While sp_mode_o is 0, execute strobes start nothing and no status bit is set.
- R3: An execute strobe with sp_mode_o=1 and busy_o=0 raises busy_o on the following cycle. A strobe that arrives while busy_o is 1, or while sp_mode_o is 0, has no effect.
- R4: While busy, each cycle processes the byte at the pointer. If the pointer differs from the compare value, the pointer increments; otherwise busy falls. busy_o stays high for (compare − start + 1) cycles, and ptr_o is left equal to the compare value, not the start.
- R5: Byte write stores the data byte at each visited address when the data has no 1 where the stored byte has a 0. Otherwise it leaves the byte unchanged and sets status bit 2.
- R6: Internal verify sets status bit 1 if any visited byte differs from the data byte.
- R7: Block erase writes FFH to the address formed from the block number (pointer bits 9:8 latched at the strobe) and pointer bits 7:0, for each visited pointer value.
- R8: Blank check sets status bit 0 if any visited byte of the latched block is not FFH.
- R9: Status bits stay set until a select-6 write carries a 1 in that bit position. A new error in the same cycle wins over the clear. No status bit rises while idle.
- R10: After reset busy_o=0, status_o=0, sp_mode_o=0, the command register holds 00H and every array byte is FFH.
- R11: Register writes to selects 0 to 5 are ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| exec_i | input | 1 | Execute strobe |
| busy_o | output | 1 | Command in progress |
| status_o | output | 3 | Sticky error flags: bit0 blank, bit1 verify, bit2 write-protect |
| sp_mode_o | output | 1 | Self-programming mode active |
| ptr_o | output | 16 | Current address pointer |

## Verification
The assertions take for granted that the compare value can be reached by counting up from the start pointer. If it cannot, a run would wrap the whole 16-bit space, and the step and end properties would still hold but would cover a very long run. They also assume that the pointer is loaded before the first strobe, because the pointer has no reset value. The stimulus always writes all five setup registers before each strobe and keeps every range inside one 256-byte block, with the end at or above the start. The directed cases that disturb a run (a second strobe, a pointer write and an illegal command during busy) are timed to land only while busy is high.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam int ST_W   = 3;

  localparam int ST_BLANK  = 0;
  localparam int ST_VERIFY = 1;
  localparam int ST_WPROT  = 2;

  localparam logic [2:0] SEL_CMD    = 3'd0;
  localparam logic [2:0] SEL_PTR_LO = 3'd1;
  localparam logic [2:0] SEL_PTR_HI = 3'd2;
  localparam logic [2:0] SEL_CMP_LO = 3'd3;
  localparam logic [2:0] SEL_CMP_HI = 3'd4;
  localparam logic [2:0] SEL_DATA   = 3'd5;
  localparam logic [2:0] SEL_CLR    = 3'd6;

  typedef enum logic [1:0] {
    OP_BLANK  = 2'b00,
    OP_VERIFY = 2'b01,
    OP_WRITE  = 2'b10,
    OP_ERASE  = 2'b11
  } fsq_op_e;

  // A command byte is accepted only when its upper six bits are clear.
  function automatic logic code_is_legal(input logic [BYTE_W-1:0] code);
    return code[BYTE_W-1:2] == '0;
  endfunction

  // True when the new byte would need a 0 cell raised to 1.
  function automatic logic raises_zero_bit(input logic [BYTE_W-1:0] old_b,
                                           input logic [BYTE_W-1:0] new_b);
    return |(new_b & ~old_b);
  endfunction

  function automatic logic byte_is_erased(input logic [BYTE_W-1:0] b);
    return b == {BYTE_W{1'b1}};
  endfunction

endpackage

// File: rtl/fsq_regs.sv
module fsq_regs
  import fsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              step,
  output logic [1:0]        cmd_q,
  output logic              sp_mode,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  cmp_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              illegal_ev
);

  logic wr_ok;
  logic hit_cmd, hit_plo, hit_phi, hit_clo, hit_chi, hit_dat;

  assign wr_ok   = reg_we && !busy;
  assign hit_cmd = wr_ok && (reg_sel == SEL_CMD);
  assign hit_plo = wr_ok && (reg_sel == SEL_PTR_LO);
  assign hit_phi = wr_ok && (reg_sel == SEL_PTR_HI);
  assign hit_clo = wr_ok && (reg_sel == SEL_CMP_LO);
  assign hit_chi = wr_ok && (reg_sel == SEL_CMP_HI);
  assign hit_dat = wr_ok && (reg_sel == SEL_DATA);

  assign illegal_ev = hit_cmd && !code_is_legal(reg_wdata);

  // Command and mode: the only state here with a defined reset value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      sp_mode <= 1'b0;
    end else if (hit_cmd) begin
      cmd_q   <= reg_wdata[1:0];
      sp_mode <= code_is_legal(reg_wdata);
    end
  end

  // Pointer: byte-loadable up counter, no reset value.
  always_ff @(posedge clk) begin
    if (hit_plo)      ptr_q[BYTE_W-1:0]     <= reg_wdata;
    else if (hit_phi) ptr_q[PTR_W-1:BYTE_W] <= reg_wdata;
    else if (step)    ptr_q                 <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hit_clo) cmp_q[BYTE_W-1:0]     <= reg_wdata;
    if (hit_chi) cmp_q[PTR_W-1:BYTE_W] <= reg_wdata;
    if (hit_dat) data_q                <= reg_wdata;
  end

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int BLK_W = 2,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic             sp_mode,
  input  logic [1:0]       cmd_q,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [PTR_W-1:0] cmp_q,
  output logic             busy,
  output fsq_op_e          op_q,
  output logic [BLK_W-1:0] blk_q,
  output logic             start_ev,
  output logic             step_ev,
  output logic             last_ev
);

  assign start_ev = exec_i && sp_mode && !busy;
  assign last_ev  = busy && (ptr_q == cmp_q);
  assign step_ev  = busy && (ptr_q != cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op_q  <= OP_BLANK;
      blk_q <= '0;
    end else if (start_ev) begin
      busy  <= 1'b1;
      op_q  <= fsq_op_e'(cmd_q);
      blk_q <= ptr_q[OFF_W +: BLK_W];
    end else if (last_ev) begin
      busy  <= 1'b0;
    end
  end

endmodule

// File: rtl/fsq_array.sv
module fsq_array
  import fsq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int BLOCK = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     proc_ev,
  input  fsq_op_e                  op,
  input  logic [$clog2(DEPTH)-1:0] ptr_idx,
  input  logic [$clog2(DEPTH)-$clog2(BLOCK)-1:0] blk,
  input  logic [BYTE_W-1:0]        data,
  output logic                     blank_ev,
  output logic                     verify_ev,
  output logic                     wprot_ev
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(BLOCK);
  localparam int BLK_W = IDX_W - OFF_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] cur;

  // Block-scoped commands take the block number latched at the strobe.
  function automatic logic [IDX_W-1:0] map_index(input fsq_op_e o,
                                                 input logic [IDX_W-1:0] p,
                                                 input logic [BLK_W-1:0] b);
    if (o == OP_ERASE || o == OP_BLANK) return {b, p[OFF_W-1:0]};
    return p;
  endfunction

  assign idx = map_index(op, ptr_idx, blk);
  assign cur = mem[idx];

  assign blank_ev  = proc_ev && (op == OP_BLANK)  && !byte_is_erased(cur);
  assign verify_ev = proc_ev && (op == OP_VERIFY) && (cur != data);
  assign wprot_ev  = proc_ev && (op == OP_WRITE)  && raises_zero_bit(cur, data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (proc_ev) begin
      case (op)
        OP_WRITE: if (!raises_zero_bit(cur, data)) mem[idx] <= data;
        OP_ERASE: mem[idx] <= '1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int BLOCK = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              exec_i,
  output logic              busy_o,
  output logic [ST_W-1:0]   status_o,
  output logic              sp_mode_o,
  output logic [PTR_W-1:0]  ptr_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(BLOCK);
  localparam int BLK_W = IDX_W - OFF_W;

  logic [1:0]        cmd_q;
  logic              sp_mode;
  logic [PTR_W-1:0]  ptr_q, cmp_q;
  logic [BYTE_W-1:0] data_q;
  logic              illegal_ev;
  logic              busy, start_ev, step_ev, last_ev;
  fsq_op_e           op_q;
  logic [BLK_W-1:0]  blk_q;
  logic              blank_ev, verify_ev, wprot_ev;
  logic [ST_W-1:0]   clr_mask, set_mask, status_q;

  fsq_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata,
    .busy, .step(step_ev),
    .cmd_q, .sp_mode, .ptr_q, .cmp_q, .data_q, .illegal_ev
  );

  fsq_ctrl #(.BLK_W(BLK_W), .OFF_W(OFF_W)) u_ctrl (
    .clk, .rst_n, .exec_i, .sp_mode, .cmd_q, .ptr_q, .cmp_q,
    .busy, .op_q, .blk_q, .start_ev, .step_ev, .last_ev
  );

  fsq_array #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_array (
    .clk, .rst_n, .proc_ev(busy), .op(op_q),
    .ptr_idx(ptr_q[IDX_W-1:0]), .blk(blk_q), .data(data_q),
    .blank_ev, .verify_ev, .wprot_ev
  );

  assign clr_mask = (reg_we && reg_sel == SEL_CLR) ? reg_wdata[ST_W-1:0] : '0;

  always_comb begin
    set_mask            = '0;
    set_mask[ST_BLANK]  = blank_ev;
    set_mask[ST_VERIFY] = verify_ev;
    set_mask[ST_WPROT]  = wprot_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | set_mask;
  end

  assign busy_o    = busy;
  assign status_o  = status_q;
  assign sp_mode_o = sp_mode;
  assign ptr_o     = ptr_q;

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker
  import fsq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_sel,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              exec_i,
  input logic              busy_o,
  input logic [ST_W-1:0]   status_o,
  input logic              sp_mode_o,
  input logic [PTR_W-1:0]  ptr_o,
  input logic [PTR_W-1:0]  cmp_q,
  input logic              blank_ev,
  input logic              verify_ev,
  input logic              wprot_ev
);

  logic [ST_W-1:0] clr_w;
  assign clr_w = (reg_we && reg_sel == SEL_CLR) ? reg_wdata[ST_W-1:0] : '0;

  assert_exec_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && sp_mode_o && !busy_o) |=> busy_o);

  assert_idle_without_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_mode_o && !busy_o) |=> !busy_o);

  assert_illegal_drops_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CMD && !busy_o && reg_wdata[BYTE_W-1:2] != '0) |=> !sp_mode_o);

  assert_ptr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ptr_o != cmp_q) |=> (busy_o && ptr_o == $past(ptr_o) + 16'd1));

  assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ptr_o == cmp_q) |=> !busy_o);

  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_o & ~clr_w)) |=> ((status_o & $past(status_o & ~clr_w)) == $past(status_o & ~clr_w)));

  assert_no_idle_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ((status_o & ~$past(status_o)) == '0));

  assert_one_error_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blank_ev, verify_ev, wprot_ev}));

endmodule

bind flash_cmd_seq fsq_checker u_fsq_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .exec_i(exec_i), .busy_o(busy_o),
  .status_o(status_o), .sp_mode_o(sp_mode_o), .ptr_o(ptr_o),
  .cmp_q(cmp_q), .blank_ev(blank_ev), .verify_ev(verify_ev),
  .wprot_ev(wprot_ev)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic       exec_i = 1'b0;
  logic       busy_o, sp_mode_o;
  logic [2:0] status_o;
  logic [15:0] ptr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_all = 0;

  always #5 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .exec_i,
    .busy_o, .status_o, .sp_mode_o, .ptr_o
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [7:0]  dat;
    logic [2:0]  st;
  } vec_t;

  // op: 0 blank, 1 verify, 2 write, 3 erase; st: expected status
  localparam vec_t VEC [15] = '{
    '{2'd0, 16'h0000, 16'h00FF, 8'h00, 3'b000},
    '{2'd2, 16'h0005, 16'h0005, 8'hA5, 3'b000},
    '{2'd1, 16'h0005, 16'h0005, 8'hA5, 3'b000},
    '{2'd1, 16'h0005, 16'h0005, 8'hA4, 3'b010},
    '{2'd0, 16'h0000, 16'h00FF, 8'h00, 3'b001},
    '{2'd2, 16'h0005, 16'h0005, 8'hFF, 3'b100},
    '{2'd1, 16'h0005, 16'h0005, 8'hA5, 3'b000},
    '{2'd2, 16'h0005, 16'h0005, 8'h21, 3'b000},
    '{2'd1, 16'h0005, 16'h0005, 8'h21, 3'b000},
    '{2'd3, 16'h0000, 16'h00FF, 8'h00, 3'b000},
    '{2'd0, 16'h0000, 16'h00FF, 8'h00, 3'b000},
    '{2'd2, 16'h01F0, 16'h01F3, 8'h3C, 3'b000},
    '{2'd1, 16'h01F0, 16'h01F3, 8'h3C, 3'b000},
    '{2'd0, 16'h0100, 16'h01FF, 8'h00, 3'b001},
    '{2'd0, 16'h0200, 16'h02FF, 8'h00, 3'b000}
  };

  function automatic string op_req(input logic [1:0] op);
    case (op)
      2'd0:    return "R8";
      2'd1:    return "R6";
      2'd2:    return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] op, input logic [15:0] lo,
                       input logic [15:0] hi, input logic [7:0] d);
    wr(3'd0, {6'b0, op});
    wr(3'd1, lo[7:0]);
    wr(3'd2, lo[15:8]);
    wr(3'd3, hi[7:0]);
    wr(3'd4, hi[15:8]);
    wr(3'd5, d);
  endtask

  // Pulses execute, then counts negedges with busy high.
  task automatic run(input bit disturb, output int cyc);
    @(negedge clk); exec_i = 1'b1;
    @(negedge clk); exec_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      cyc++;
      if (disturb) begin
        if (cyc == 10) exec_i = 1'b1;
        if (cyc == 11) exec_i = 1'b0;
        if (cyc == 20) begin reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 8'h00; end
        if (cyc == 21) reg_we = 1'b0;
        if (cyc == 30) begin reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 8'h07; end
        if (cyc == 31) reg_we = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
    check(status_o == 3'b000, "R10", "status after reset", status_o, 0);
    check(sp_mode_o == 1'b0, "R10", "mode after reset", sp_mode_o, 0);
    // R3: strobe outside mode is ignored
    @(negedge clk); exec_i = 1'b1;
    @(negedge clk); exec_i = 1'b0;
    check(busy_o == 1'b0, "R3", "busy on strobe without mode", busy_o, 0);
    // R1: legal command enters mode
    wr(3'd0, 8'h00);
    check(sp_mode_o == 1'b1, "R1", "mode after legal command", sp_mode_o, 1);

    for (int i = 0; i < 15; i++) begin
      vec_t v;
      int exp_cyc;
      v = VEC[i];
      exp_cyc = int'(v.hi - v.lo) + 1;
      setup(v.op, v.lo, v.hi, v.dat);
      run(1'b0, cyc);
      check(status_o == v.st, op_req(v.op), $sformatf("status vec %0d", i), status_o, v.st);
      check(cyc == exp_cyc, "R4", $sformatf("busy cycles vec %0d", i), cyc, exp_cyc);
      check(ptr_o == v.hi, "R4", $sformatf("final pointer vec %0d", i), ptr_o, v.hi);
      wr(3'd6, 8'h07);
    end

    // R2: illegal command leaves mode, strobe ignored, no flag
    wr(3'd0, 8'h05);
    check(sp_mode_o == 1'b0, "R2", "mode after illegal code", sp_mode_o, 0);
    @(negedge clk); exec_i = 1'b1;
    @(negedge clk); exec_i = 1'b0;
    check(busy_o == 1'b0, "R2", "busy after strobe out of mode", busy_o, 0);
    check(status_o == 3'b000, "R2", "status after illegal code", status_o, 0);

    // R3 / R11: strobe, pointer write and illegal code during a run
    setup(2'd0, 16'h0200, 16'h02FF, 8'h00);
    run(1'b1, cyc);
    check(cyc == 256, "R3", "cycles with strobe during busy", cyc, 256);
    check(ptr_o == 16'h02FF, "R11", "pointer after write during busy", ptr_o, 16'h02FF);
    check(sp_mode_o == 1'b1, "R11", "mode after command write during busy", sp_mode_o, 1);
    check(status_o == 3'b000, "R11", "status after disturbed run", status_o, 0);

    // R9: sticky bits and partial write-1-to-clear
    setup(2'd0, 16'h0100, 16'h01FF, 8'h00);
    run(1'b0, cyc);
    setup(2'd1, 16'h01F0, 16'h01F0, 8'h00);
    run(1'b0, cyc);
    check(status_o == 3'b011, "R9", "two sticky flags", status_o, 3);
    wr(3'd6, 8'h02);
    check(status_o == 3'b001, "R9", "after clearing bit 1", status_o, 1);
    wr(3'd6, 8'h01);
    check(status_o == 3'b000, "R9", "after clearing bit 0", status_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule